// File: doc/BRIEF.md
# Three-LED Pattern Sequencer with Latched Mode

This block is a small Moore state machine that drives three LED outputs. While the synchronous reset is high it sits idle with every LED dark. When reset is low and the advance strobe is high at a clock edge, the machine leaves idle. The level of the mode-select input at that edge fixes which of two patterns it will run. In rotate mode a single lit LED moves from left to right and wraps around. In alternate mode the outer pair and the middle LED take turns being lit.

The choice is held for the whole run. Once the machine has left idle, later changes on the mode-select input have no effect until reset returns it to idle. The advance strobe gates every transition that is not a reset. This lets a slow one-cycle tick pace the patterns while the block runs on a fast system clock. The block has no data stream, so every pin is a plain control or status level.

Bit 2 of `led` is the leftmost LED and bit 0 is the rightmost. A written pattern such as 100 lists bits 2, 1, 0 in that order.

Top module: `led_seq_top`

## Requirements
- R1: When `rst` is 1 at a clock edge, `led` is 000 after that edge, whatever the values of `step_en` and `sel_rotate`.
- R2: When `rst` is 0 and `step_en` is 0 at a clock edge, `led` keeps its value across that edge.
- R3: From idle, an edge with `rst`=0 and `step_en`=1 gives `led`=100 if `sel_rotate` is 1 and `led`=101 if `sel_rotate` is 0.
- R4: In rotate mode, each edge with `step_en`=1 moves `led` through 100, 010, 001 and then back to 100.
- R5: In alternate mode, each edge with `step_en`=1 swaps `led` between 101 and 010.
- R6: While a pattern is running, the value of `sel_rotate` has no effect on `led`.
- R7: After a run, a new value of `sel_rotate` selects the pattern only on the first advance after reset has been asserted again.
- R8: `led` only ever shows one of 000, 100, 010, 001 or 101, and it is driven straight from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to idle; overrides everything else |
| step_en | input | 1 | Advance strobe; the pattern moves one step on edges where it is 1 |
| sel_rotate | input | 1 | Mode select, sampled only when leaving idle: 1 = rotate, 0 = alternate |
| led | output | 3 | Registered LED drive; bit 2 is the leftmost LED |

## Verification
The assertions assume that `rst` has been high at least once before any output is judged, so the power-up value of the state register is never checked. They also assume that every input is a synchronous level that is stable around the rising edge, with no limit on how often `step_en` or `sel_rotate` may change. The bench meets these assumptions in three ways. It starts with several reset cycles. It changes inputs one nanosecond after each rising edge. It mixes directed runs, in which `sel_rotate` toggles during a pattern and `step_en` stalls, with a long random stretch in which reset, strobe and select are drawn independently.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

  localparam int unsigned LED_W   = 3;
  localparam int unsigned STATE_W = 3;

  // Six named states; codes 3'b110 and 3'b111 are unused and recover to idle.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE    = 3'b000,
    ST_ROT_L   = 3'b001,
    ST_ROT_M   = 3'b010,
    ST_ROT_R   = 3'b011,
    ST_ALT_OUT = 3'b100,
    ST_ALT_MID = 3'b101
  } seq_state_e;

  localparam logic [LED_W-1:0] PAT_DARK  = 3'b000;
  localparam logic [LED_W-1:0] PAT_LEFT  = 3'b100;
  localparam logic [LED_W-1:0] PAT_MID   = 3'b010;
  localparam logic [LED_W-1:0] PAT_RIGHT = 3'b001;
  localparam logic [LED_W-1:0] PAT_OUTER = 3'b101;

endpackage

// File: rtl/led_seq_next.sv
module led_seq_next
  import led_seq_pkg::*;
(
  input  seq_state_e cur,
  input  logic       rst,
  input  logic       step_en,
  input  logic       sel_rotate,
  output seq_state_e nxt
);

  always_comb begin
    nxt = cur;
    if (rst) begin
      nxt = ST_IDLE;
    end else if (step_en) begin
      case (cur)
        ST_IDLE:    nxt = sel_rotate ? ST_ROT_L : ST_ALT_OUT;
        ST_ROT_L:   nxt = ST_ROT_M;
        ST_ROT_M:   nxt = ST_ROT_R;
        ST_ROT_R:   nxt = ST_ROT_L;
        ST_ALT_OUT: nxt = ST_ALT_MID;
        ST_ALT_MID: nxt = ST_ALT_OUT;
        default:    nxt = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/led_seq_decode.sv
module led_seq_decode
  import led_seq_pkg::*;
(
  input  seq_state_e       st,
  output logic [LED_W-1:0] pat
);

  always_comb begin
    case (st)
      ST_ROT_L:   pat = PAT_LEFT;
      ST_ROT_M:   pat = PAT_MID;
      ST_ROT_R:   pat = PAT_RIGHT;
      ST_ALT_OUT: pat = PAT_OUTER;
      ST_ALT_MID: pat = PAT_MID;
      default:    pat = PAT_DARK;
    endcase
  end

endmodule

// File: rtl/led_seq_top.sv
module led_seq_top
  import led_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             sel_rotate,
  output logic [LED_W-1:0] led
);

  seq_state_e       state_q;
  seq_state_e       state_d;
  logic [LED_W-1:0] pat_d;
  logic [LED_W-1:0] led_q;

  led_seq_next u_next (
    .cur        (state_q),
    .rst        (rst),
    .step_en    (step_en),
    .sel_rotate (sel_rotate),
    .nxt        (state_d)
  );

  // Decode the next state so the LED register matches the state register.
  led_seq_decode u_dec (
    .st  (state_d),
    .pat (pat_d)
  );

  // Reset is folded into state_d, so both registers clear synchronously.
  always_ff @(posedge clk) begin
    state_q <= state_d;
    led_q   <= pat_d;
  end

  assign led = led_q;

endmodule

// File: rtl/led_seq_chk.sv
module led_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_en,
  input logic       sel_rotate,
  input logic [2:0] led
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | rst;

  // R1
  idle_dark_chk: assert property (@(posedge clk) disable iff (!armed)
    rst |=> led == 3'b000);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    !step_en |=> $stable(led));

  // R3
  leave_rotate_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (led == 3'b000 && step_en && sel_rotate) |=> led == 3'b100);

  // R3
  leave_alternate_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (led == 3'b000 && step_en && !sel_rotate) |=> led == 3'b101);

  // R4
  rotate_left_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (led == 3'b100 && step_en) |=> led == 3'b010);

  // R4
  rotate_wrap_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (led == 3'b001 && step_en) |=> led == 3'b100);

  // R5
  alt_outer_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (led == 3'b101 && step_en) |=> led == 3'b010);

  // R6
  alt_locked_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (led == 3'b010 && $past(led) == 3'b101 && step_en) |=> led == 3'b101);

  // R8
  legal_pattern_chk: assert property (@(posedge clk) disable iff (!armed)
    led inside {3'b000, 3'b100, 3'b010, 3'b001, 3'b101});

endmodule

bind led_seq_top led_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_en    (step_en),
  .sel_rotate (sel_rotate),
  .led        (led)
);

// File: tb/tb_led_seq_top.sv
`timescale 1ns/1ps
module tb_led_seq_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_en = 1'b0;
  logic       sel_rotate = 1'b0;
  logic [2:0] led;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Reference model: mode 0 idle, 1 rotate, 2 alternate.
  int mode  = 0;
  int phase = 0;

  always #10 clk = ~clk;

  led_seq_top dut (
    .clk        (clk),
    .rst        (rst),
    .step_en    (step_en),
    .sel_rotate (sel_rotate),
    .led        (led)
  );

  function automatic logic [2:0] expect_led();
    if (mode == 1) return (phase == 0) ? 3'b100 : (phase == 1) ? 3'b010 : 3'b001;
    if (mode == 2) return (phase == 0) ? 3'b101 : 3'b010;
    return 3'b000;
  endfunction

  task automatic step(input logic r, input logic e, input logic s, input string tag);
    logic [2:0] exp_v;
    rst = r; step_en = e; sel_rotate = s;
    @(posedge clk);
    if (r) begin
      mode = 0; phase = 0;
    end else if (e) begin
      if (mode == 0) begin
        mode = s ? 1 : 2; phase = 0;
      end else begin
        phase = (phase + 1) % ((mode == 1) ? 3 : 2);
      end
    end
    #1;
    exp_v = expect_led();
    n_cmp++;
    if (led !== exp_v) begin
      n_bad++;
      $display("FAIL %s: led=%b expected=%b at %0t", tag, led, exp_v, $time);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: expected run to finish, actual still running");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with strobe high to show reset priority
    step(1, 0, 0, "R1");
    step(1, 1, 1, "R1");
    step(1, 1, 0, "R1");
    // R3 leave idle in rotate mode, then R4 rotation with R6 select toggling
    step(0, 1, 1, "R3");
    for (int i = 0; i < 7; i++) step(0, 1, i[0], "R4_R6");
    // R2 stall holds the current pattern
    for (int i = 0; i < 4; i++) step(0, 0, i[1], "R2");
    step(0, 1, 0, "R4");
    // R1 reset during a run
    step(1, 1, 1, "R1");
    // R7 new selection after reset gives alternate, R3
    step(0, 1, 0, "R3_R7");
    for (int i = 0; i < 6; i++) step(0, 1, ~i[0], "R5_R6");
    step(0, 0, 1, "R2");
    step(0, 1, 1, "R5");
    // R7 holding in idle with stalls, then select rotate
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R2");
    step(0, 1, 1, "R7");
    step(0, 1, 0, "R4");
    // Random stretch: R8 patterns plus every rule above
    for (int i = 0; i < 3000; i++) begin
      logic r, e, s;
      r = ($urandom_range(0, 19) == 0);
      e = ($urandom_range(0, 3) != 0);
      s = $urandom_range(0, 1) == 1;
      step(r, e, s, "R8_random");
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule